// File: doc/BRIEF.md
# Two-Wire Serial Register Read Slave

This block is a slave on a two-wire serial bus (clock line and open-drain data line) that lets a bus master read a small register file kept elsewhere on the chip. Both bus lines are oversampled by the system clock through a synchronizer. A transfer opens with a START condition and a 7-bit device address. A write transfer carries one byte that sets the block's register pointer. A read transfer streams register bytes out, starting at that pointer.

A random read is a write transfer that loads the pointer, then a repeated START and a read transfer. In the read transfer the slave sends one byte for every acknowledge the master gives. The pointer advances after each byte and wraps around the register space. The master ends the read with a not-acknowledge followed by STOP. The register file itself sits outside the block: the block presents the pointer on `reg_addr` and takes the addressed byte back combinationally on `reg_rdata`. The data line is driven only low, through `sda_oe`.

Top module: `sbus_read_slave`

## Requirements
- R1: While reset is asserted and right after it is released, `sda_oe` is 0 and `reg_addr` is 0.
- R2: After a START, the slave acknowledges an address byte whose upper seven bits (sent first) equal `SLAVE_ADDR`. It does this by holding `sda_oe` high across the ninth clock pulse. This holds for R/W (eighth bit) = 0 and for R/W = 1.
- R3: After a START with a non-matching address, the slave never drives the data line until the next START. This covers the ninth clock pulse and any bytes that follow.
- R4: In a write transfer, the slave acknowledges the byte that follows the address. Its low `ADDR_W` bits become the pointer, and `reg_addr` shows the pointer once the acknowledge has been given. The upper bits of that byte have no effect.
- R5: In a read transfer, the slave sends `reg_rdata` for the current pointer, most significant bit first. A 0 bit is sent by driving low, and a 1 bit by releasing the line.
- R6: After each byte sent, the pointer increments by one and wraps from 2**ADDR_W-1 to 0. A master acknowledge (data line low on the ninth pulse) makes the slave send the byte at the new pointer.
- R7: After a master not-acknowledge (data line high on the ninth pulse), the slave releases the data line until the next START. A STOP always leaves `sda_oe` at 0.
- R8: `sda_oe` changes only while the clock line is low. The slave samples master bits on the rising edge of the clock line and changes its own drive after the falling edge.
- R9: Any byte that follows the pointer byte in a write transfer is not acknowledged, and it leaves the pointer unchanged.
- R10: A START or repeated START in the middle of a byte abandons that byte. Address reception begins afresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | High pulls the data line low |
| reg_addr | output | ADDR_W | Register pointer presented to the register file |
| reg_rdata | input | 8 | Register byte at `reg_addr` |

## Verification
The bench uses `SLAVE_ADDR` = 7'h52 with the default `ADDR_W` = 5. A 32-entry space lets random pointers and short random burst lengths cross the wrap from 31 to 0 often, and a directed burst starting at 30 also crosses it. Random pointer bytes carry random upper bits, which exercises the rule that only the low five bits count. Random non-matching addresses are drawn against the fixed address. Eight bus-clock-low system cycles per phase leave room for the synchronizer delay, so drive changes are seen to fall inside the low phase.

// File: rtl/sbus_pkg.sv
package sbus_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_CHK,
    ST_SACK,
    ST_WADDR,
    ST_WADDR_CHK,
    ST_TX,
    ST_TX_END,
    ST_MACK,
    ST_MACK_OK,
    ST_IGNORE
  } sbus_state_t;

  typedef enum logic [1:0] {
    PH_WR,
    PH_RD,
    PH_PTR
  } sbus_phase_t;
endpackage

// File: rtl/sbus_line_sense.sv
module sbus_line_sense #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_p,
  output logic stop_p
);
  logic [SYNC_STAGES-1:0] scl_chain;
  logic [SYNC_STAGES-1:0] sda_chain;
  logic scl_d;
  logic sda_d;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_chain <= '1;
          sda_chain <= '1;
        end else begin
          scl_chain <= scl_i;
          sda_chain <= sda_i;
        end
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_chain <= '1;
          sda_chain <= '1;
        end else begin
          scl_chain <= {scl_chain[SYNC_STAGES-2:0], scl_i};
          sda_chain <= {sda_chain[SYNC_STAGES-2:0], sda_i};
        end
      end
    end
  endgenerate

  assign scl_s = scl_chain[SYNC_STAGES-1];
  assign sda_s = sda_chain[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
  assign start_p  = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_p   = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/sbus_engine.sv
module sbus_engine
  import sbus_pkg::*;
#(
  parameter int            ADDR_W     = 5,
  parameter logic [6:0]    SLAVE_ADDR = 7'h2C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_p,
  input  logic              stop_p,
  input  logic [BYTE_W-1:0] rdata,
  output logic              sda_oe,
  output logic [ADDR_W-1:0] ptr,
  output logic              ignoring,
  output logic              loading
);
  localparam logic [2:0] LAST_BIT = 3'(BYTE_W - 1);

  sbus_state_t        state, state_n;
  sbus_phase_t        phase, phase_n;
  logic [2:0]         cnt, cnt_n;
  logic [BYTE_W-1:0]  sh, sh_n;
  logic [ADDR_W-1:0]  ptr_n;
  logic               oe_n;

  always_comb begin
    state_n = state;
    phase_n = phase;
    cnt_n   = cnt;
    sh_n    = sh;
    ptr_n   = ptr;
    oe_n    = sda_oe;
    if (stop_p) begin
      state_n = ST_IDLE;
      oe_n    = 1'b0;
    end else if (start_p) begin
      state_n = ST_ADDR;
      cnt_n   = '0;
      oe_n    = 1'b0;
    end else begin
      unique case (state)
        ST_ADDR, ST_WADDR: begin
          if (scl_rise) begin
            sh_n = {sh[BYTE_W-2:0], sda_s};
            if (cnt == LAST_BIT) state_n = (state == ST_ADDR) ? ST_ADDR_CHK : ST_WADDR_CHK;
            else                 cnt_n   = cnt + 3'd1;
          end
        end
        ST_ADDR_CHK: begin
          if (scl_fall) begin
            if (sh[BYTE_W-1:1] == SLAVE_ADDR) begin
              oe_n    = 1'b1;
              phase_n = sh[0] ? PH_RD : PH_WR;
              state_n = ST_SACK;
            end else begin
              state_n = ST_IGNORE;
            end
          end
        end
        ST_WADDR_CHK: begin
          if (scl_fall) begin
            ptr_n   = sh[ADDR_W-1:0];
            oe_n    = 1'b1;
            phase_n = PH_PTR;
            state_n = ST_SACK;
          end
        end
        ST_SACK: begin
          if (scl_fall) begin
            oe_n  = 1'b0;
            cnt_n = '0;
            unique case (phase)
              PH_WR:   state_n = ST_WADDR;
              PH_RD: begin
                sh_n    = rdata;
                oe_n    = ~rdata[BYTE_W-1];
                state_n = ST_TX;
              end
              default: state_n = ST_IGNORE;
            endcase
          end
        end
        ST_TX: begin
          if (scl_rise) begin
            if (cnt == LAST_BIT) state_n = ST_TX_END;
            else                 cnt_n   = cnt + 3'd1;
          end else if (scl_fall) begin
            sh_n = {sh[BYTE_W-2:0], 1'b0};
            oe_n = ~sh[BYTE_W-2];
          end
        end
        ST_TX_END: begin
          if (scl_fall) begin
            oe_n    = 1'b0;
            ptr_n   = ptr + 1'b1;
            state_n = ST_MACK;
          end
        end
        ST_MACK: begin
          if (scl_rise) state_n = sda_s ? ST_IGNORE : ST_MACK_OK;
        end
        ST_MACK_OK: begin
          if (scl_fall) begin
            sh_n    = rdata;
            oe_n    = ~rdata[BYTE_W-1];
            cnt_n   = '0;
            state_n = ST_TX;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      phase  <= PH_WR;
      cnt    <= '0;
      sh     <= '0;
      ptr    <= '0;
      sda_oe <= 1'b0;
    end else begin
      state  <= state_n;
      phase  <= phase_n;
      cnt    <= cnt_n;
      sh     <= sh_n;
      ptr    <= ptr_n;
      sda_oe <= oe_n;
    end
  end

  assign ignoring = (state == ST_IGNORE);
  assign loading  = (state == ST_WADDR_CHK);
endmodule

// File: rtl/sbus_read_slave.sv
module sbus_read_slave #(
  parameter int         ADDR_W      = 5,
  parameter logic [6:0] SLAVE_ADDR  = 7'h2C,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_rdata
);
  logic [1:0] rst_pipe;
  logic       rst_sync_n;
  logic       scl_sync, sda_sync;
  logic       scl_rise, scl_fall, start_p, stop_p;
  logic       ignoring, loading;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  sbus_line_sense #(.SYNC_STAGES(SYNC_STAGES)) u_sense (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .scl_s    (scl_sync),
    .sda_s    (sda_sync),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_p  (start_p),
    .stop_p   (stop_p)
  );

  sbus_engine #(.ADDR_W(ADDR_W), .SLAVE_ADDR(SLAVE_ADDR)) u_engine (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .sda_s    (sda_sync),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_p  (start_p),
    .stop_p   (stop_p),
    .rdata    (reg_rdata),
    .sda_oe   (sda_oe),
    .ptr      (reg_addr),
    .ignoring (ignoring),
    .loading  (loading)
  );
endmodule

// File: rtl/sbus_read_slave_chk.sv
module sbus_read_slave_chk #(
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_sync,
  input logic              stop_seen,
  input logic              ignoring,
  input logic              loading,
  input logic              sda_oe,
  input logic [ADDR_W-1:0] reg_addr
);
  // R8: drive changes only while the synchronized clock line is low
  assert_drive_in_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_sync);

  // R3 / R7: ignoring the bus means the data line is released
  assert_ignore_released_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ignoring |-> !sda_oe);

  // R7: a STOP always leaves the line released
  assert_stop_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stop_seen |=> !sda_oe);

  // R6: outside a pointer load, the pointer only steps by one
  assert_ptr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(reg_addr) && !$past(loading)) |-> (reg_addr == ADDR_W'($past(reg_addr) + 1'b1)));
endmodule

bind sbus_read_slave sbus_read_slave_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .scl_sync  (scl_sync),
  .stop_seen (stop_p),
  .ignoring  (ignoring),
  .loading   (loading),
  .sda_oe    (sda_oe),
  .reg_addr  (reg_addr)
);

// File: tb/sbus_read_slave_test.sv
`timescale 1ns/1ps
module sbus_read_slave_test;
  localparam int         ADDR_W = 5;
  localparam logic [6:0] SA     = 7'h52;
  localparam int         Q      = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_line;
  logic sda_oe;
  logic [ADDR_W-1:0] reg_addr;
  logic [7:0] reg_rdata;
  int total = 0;
  int bad = 0;
  int r8_viol = 0;
  logic prev_oe = 1'b0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  function automatic logic [7:0] model(input logic [ADDR_W-1:0] a);
    return (8'(a) * 8'd29 + 8'd7) ^ 8'hA5;
  endfunction

  assign sda_line  = m_sda & ~sda_oe;
  assign reg_rdata = model(reg_addr);

  sbus_read_slave #(.ADDR_W(ADDR_W), .SLAVE_ADDR(SA)) uut (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .sda_oe(sda_oe), .reg_addr(reg_addr), .reg_rdata(reg_rdata));

  // R8 monitor: drive must not change while the clock line is high
  always @(negedge clk) begin
    if (rst_n && m_scl && (sda_oe !== prev_oe)) r8_viol++;
    prev_oe <= sda_oe;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic start_cond();
    m_sda = 1'b1; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic stop_cond();
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_sda = 1'b1; tick(Q);
  endtask

  task automatic put_bit(input logic b);
    m_sda = b; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_scl = 1'b0; tick(2);
  endtask

  task automatic get_bit(output logic b);
    m_sda = 1'b1; tick(Q);
    m_scl = 1'b1; tick(Q/2);
    b = sda_line; tick(Q/2);
    m_scl = 1'b0; tick(2);
  endtask

  task automatic write_byte(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(b);
    ack = ~b;
  endtask

  task automatic read_byte(input logic give_ack, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      v[i] = b;
    end
    put_bit(~give_ack);
  endtask

  // full random read: pointer load, repeated START, burst of len bytes
  task automatic random_read(input logic [7:0] wa, input int len);
    logic ack;
    logic [7:0] v;
    logic [ADDR_W-1:0] p;
    start_cond();
    write_byte({SA, 1'b0}, ack);
    check(ack, "R2", int'(ack), 1);
    write_byte(wa, ack);
    check(ack, "R4", int'(ack), 1);
    check(reg_addr == wa[ADDR_W-1:0], "R4", int'(reg_addr), int'(wa[ADDR_W-1:0]));
    start_cond();
    write_byte({SA, 1'b1}, ack);
    check(ack, "R2", int'(ack), 1);
    p = wa[ADDR_W-1:0];
    for (int k = 0; k < len; k++) begin
      read_byte(k < len - 1, v);
      check(v == model(p), (k == 0) ? "R5" : "R6", int'(v), int'(model(p)));
      p = p + 1'b1;
    end
    check(reg_addr == p, "R6", int'(reg_addr), int'(p));
    check(sda_oe == 1'b0, "R7", int'(sda_oe), 0);
    stop_cond();
    check(sda_oe == 1'b0, "R7", int'(sda_oe), 0);
  endtask

  initial begin
    tick(500000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic ack, b, all_one;
    logic [7:0] v;
    logic [6:0] other;
    logic [ADDR_W-1:0] keep;
    void'($urandom(32'd1234));
    tick(3);
    check(sda_oe == 1'b0, "R1", int'(sda_oe), 0);
    check(reg_addr == '0, "R1", int'(reg_addr), 0);
    rst_n = 1'b1;
    tick(4);
    check(sda_oe == 1'b0, "R1", int'(sda_oe), 0);
    check(reg_addr == '0, "R1", int'(reg_addr), 0);

    // directed: wrap across the top of the register space
    random_read(8'hFE, 4);

    // R7: after a NACK the line stays released for further clocks
    start_cond();
    write_byte({SA, 1'b1}, ack);
    check(ack, "R2", int'(ack), 1);
    read_byte(1'b0, v);
    all_one = 1'b1;
    for (int i = 0; i < 9; i++) begin
      get_bit(b);
      all_one &= b;
    end
    check(all_one, "R7", int'(all_one), 1);
    stop_cond();

    // R3: mismatched addresses are never acknowledged
    for (int t = 0; t < 6; t++) begin
      other = 7'($urandom);
      if (other == SA) other = SA ^ 7'h01;
      start_cond();
      write_byte({other, 1'($urandom)}, ack);
      check(!ack, "R3", int'(ack), 0);
      all_one = 1'b1;
      for (int i = 0; i < 9; i++) begin
        get_bit(b);
        all_one &= b;
      end
      check(all_one, "R3", int'(all_one), 1);
      stop_cond();
    end

    // R9: extra write byte gets NACK, pointer kept
    start_cond();
    write_byte({SA, 1'b0}, ack);
    write_byte(8'h0B, ack);
    keep = reg_addr;
    write_byte(8'h77, ack);
    check(!ack, "R9", int'(ack), 0);
    check(reg_addr == keep, "R9", int'(reg_addr), int'(keep));
    stop_cond();
    check(reg_addr == keep, "R9", int'(reg_addr), int'(keep));

    // R10: START inside a byte abandons it
    start_cond();
    put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
    random_read(8'h11, 2);
    start_cond();
    put_bit(SA[6]); put_bit(SA[5]);
    start_cond();
    write_byte({SA, 1'b1}, ack);
    check(ack, "R10", int'(ack), 1);
    read_byte(1'b0, v);
    check(v == model(5'h13), "R10", int'(v), int'(model(5'h13)));
    stop_cond();

    // constrained random bursts
    for (int t = 0; t < 24; t++) begin
      random_read(8'($urandom), 1 + int'($urandom_range(0, 5)));
    end

    check(r8_viol == 0, "R8", r8_viol, 0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule